// File: doc/BRIEF.md
# ADC Test Pattern Generator

This block sits behind the sample path of a multi-channel converter and can replace each channel's conversion results with a known stimulus word, so that a downstream receiver can be trained, deskewed and checked for bit errors. Every channel has its own 4-bit mode field. It chooses between passing the live samples and a set of synthetic sequences: constants, an alternating bit toggle, a ramp, one or two programmable custom words, a fixed deskew word, a pseudo-random sequence and an 8-point sine. The two custom words are shared by all channels.

Sample words enter and leave on a valid/ready stream, with one word per channel in every beat. A beat is accepted when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the single output register is empty or is being drained in the same cycle, so back-pressure on `m_ready` reaches the input in the same cycle. Sequences advance only on accepted beats. A stall therefore never skips or repeats a pattern step. An alignment control restarts every channel's sequence at the same beat, which keeps channels that run the same mode in lockstep.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: `s_ready` equals `!m_valid || m_ready`. A beat accepted on a clock edge appears on `m_data` with `m_valid` high after that edge. While `m_valid` is high and `m_ready` is low, `m_data` holds steady and `m_valid` stays high. With `m_ready` high and no new beat, `m_valid` falls.
- R2: Reset (active-low `rst_n`) clears `m_valid` and leaves `s_ready` high. It also clears each channel's remembered mode to 0 and the remembered alignment to 0, so the first beat after reset in any non-zero mode starts its sequence from the beginning.
- R3: Channel c takes its mode from `chan_mode[4c+3:4c]` and its words from bits `[16c+15:16c]` of `s_data` and `m_data`. Mode 0 passes the live input word, mode 1 gives 0000h and mode 2 gives FFFFh.
- R4: Mode 3 gives AAAAh on the first beat of its sequence, then alternates with 5555h on every accepted beat.
- R5: Mode 4 gives a ramp. It starts at 0 on the first beat, adds 1 on every accepted beat, and wraps from FFFFh to 0000h.
- R6: Mode 6 gives `custom_a`. Mode 7 alternates `custom_a` and `custom_b`, starting with `custom_a`. Both words are sampled on the accepted beat.
- R7: Mode 8 gives the constant deskew word AAAAh.
- R8: Mode 10 gives a pseudo-random sequence. A 15-bit shift state starts at 7FFFh on the first beat. For every output bit, the new bit is state[14] XOR state[13], and the state shifts left taking that bit in as its LSB. Each beat produces 16 new bits, and the first bit produced lands in bit 15.
- R9: Mode 11 repeats, from the first beat, the words 1, 9598, 32768, 55938, 65535, 55938, 32768, 9598 (decimal).
- R10: The reserved modes 5, 9, 12, 13, 14 and 15 give 0000h.
- R11: With `align_en` low, a channel restarts its sequence on any accepted beat whose mode differs from the mode of its previous accepted beat. A mode change on one channel leaves the other channels' sequences running on.
- R12: With `align_en` high, every channel restarts together on an accepted beat in either of two cases: some channel's mode changed, or alignment was low on the previous accepted beat. Channels in the same non-zero mode then give identical words on every beat.
- R13: No sequence advances on a cycle without an accepted beat. The word after a stall is the next step after the word before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| align_en | input | 1 | Lockstep restart of all channel sequences |
| chan_mode | input | 8 | 4-bit mode per channel, channel 0 in the low nibble |
| custom_a | input | 16 | First shared custom word |
| custom_b | input | 16 | Second shared custom word |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat can be accepted |
| s_data | input | 32 | Live sample words, channel 0 in the low half |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the output beat |
| m_data | output | 32 | Output words, channel 0 in the low half |

## Verification
A reference model in the bench steps every mode through several beats, with the channels aligned and free-running. It checks whether a mode change restarts only its own channel or, under alignment, all of them. A design that restarted on the wrong beats would show a ramp or toggle out of phase. A design that let one channel's change reach its neighbour would break the ramp still running on the other channel. The ramp is driven through a full wrap from FFFFh to 0000h, which catches a counter that saturates or is too narrow. A stall holds the output while `s_valid` stays high, so a generator that advanced on cycles instead of accepted beats would skip a step. A mid-run reset must restart the sequence, so a design that kept its state across reset would resume the old ramp.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int MODE_W = 4;
  localparam int LFSR_W = 15;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

  typedef enum logic [MODE_W-1:0] {
    PAT_LIVE     = 4'd0,
    PAT_ZERO     = 4'd1,
    PAT_ONES     = 4'd2,
    PAT_TOGGLE   = 4'd3,
    PAT_RAMP     = 4'd4,
    PAT_CUST1    = 4'd6,
    PAT_CUST_ALT = 4'd7,
    PAT_DESKEW   = 4'd8,
    PAT_PRBS     = 4'd10,
    PAT_SINE     = 4'd11
  } pat_mode_e;

  // Eight-point sine, 16-bit full scale
  function automatic logic [15:0] sine_point(input logic [2:0] idx);
    case (idx)
      3'd0:    return 16'h0001;
      3'd1:    return 16'h257E;
      3'd2:    return 16'h8000;
      3'd3:    return 16'hDA82;
      3'd4:    return 16'hFFFF;
      3'd5:    return 16'hDA82;
      3'd6:    return 16'h8000;
      default: return 16'h257E;
    endcase
  endfunction
endpackage

// File: rtl/tpg_lane.sv
module tpg_lane
  import tpg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              restart,
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     live,
  input  logic [DW-1:0]     cust_a,
  input  logic [DW-1:0]     cust_b,
  output logic [DW-1:0]     word
);
  localparam logic [DW-1:0] TOG = DW'({DW{2'b10}});

  logic [DW-1:0]     step_q, eff_step;
  logic [LFSR_W-1:0] lfsr_q, eff_lfsr, lfsr_nxt;
  logic [DW-1:0]     prbs_word, sine_word;
  logic [DW+15:0]    sine_ext;

  assign eff_step = restart ? '0 : step_q;
  assign eff_lfsr = restart ? LFSR_SEED : lfsr_q;

  // DW serial steps of the shift register per beat, first bit to the MSB
  always_comb begin
    logic [LFSR_W-1:0] s;
    logic              fb;
    s = eff_lfsr;
    prbs_word = '0;
    for (int i = 0; i < DW; i++) begin
      fb = s[LFSR_W-1] ^ s[LFSR_W-2];
      prbs_word[DW-1-i] = fb;
      s = {s[LFSR_W-2:0], fb};
    end
    lfsr_nxt = s;
  end

  // Sine left-justified onto the lane width
  assign sine_ext  = {sine_point(eff_step[2:0]), DW'(0)};
  assign sine_word = DW'(sine_ext >> 16);

  always_comb begin
    case (mode)
      PAT_LIVE:     word = live;
      PAT_ZERO:     word = '0;
      PAT_ONES:     word = '1;
      PAT_TOGGLE:   word = eff_step[0] ? ~TOG : TOG;
      PAT_RAMP:     word = eff_step;
      PAT_CUST1:    word = cust_a;
      PAT_CUST_ALT: word = eff_step[0] ? cust_b : cust_a;
      PAT_DESKEW:   word = TOG;
      PAT_PRBS:     word = prbs_word;
      PAT_SINE:     word = sine_word;
      default:      word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      lfsr_q <= LFSR_SEED;
    end else if (adv) begin
      step_q <= eff_step + 1'b1;
      lfsr_q <= lfsr_nxt;
    end
  end
endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
  import tpg_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  align_en,
  input  logic [NCH*MODE_W-1:0] chan_mode,
  input  logic [DW-1:0]         custom_a,
  input  logic [DW-1:0]         custom_b,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [NCH*DW-1:0]     s_data,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [NCH*DW-1:0]     m_data
);
  logic                  adv;
  logic                  any_change;
  logic                  align_q;
  logic [NCH*MODE_W-1:0] mode_q;
  logic [NCH-1:0]        restart;
  logic [NCH*DW-1:0]     lane_word;

  assign s_ready = !m_valid || m_ready;
  assign adv     = s_valid && s_ready;

  always_comb begin
    any_change = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (chan_mode[c*MODE_W +: MODE_W] != mode_q[c*MODE_W +: MODE_W])
        any_change = 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign restart[g] =
      (chan_mode[g*MODE_W +: MODE_W] != mode_q[g*MODE_W +: MODE_W]) ||
      (align_en && (any_change || !align_q));

    tpg_lane #(.DW(DW)) i_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .restart (restart[g]),
      .mode    (chan_mode[g*MODE_W +: MODE_W]),
      .live    (s_data[g*DW +: DW]),
      .cust_a  (custom_a),
      .cust_b  (custom_b),
      .word    (lane_word[g*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      mode_q  <= '0;
      align_q <= 1'b0;
    end else if (adv) begin
      m_valid <= 1'b1;
      m_data  <= lane_word;
      mode_q  <= chan_mode;
      align_q <= align_en;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_tpg_checker.sv
module adc_tpg_checker #(
  parameter int NCH = 2,
  parameter int DW  = 16,
  parameter int MW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              align_en,
  input logic [NCH*MW-1:0] chan_mode,
  input logic              s_valid,
  input logic              s_ready,
  input logic [NCH*DW-1:0] s_data,
  input logic              m_valid,
  input logic              m_ready,
  input logic [NCH*DW-1:0] m_data
);
  localparam logic [DW-1:0] DESKEW = DW'({DW{2'b10}});

  logic beat;
  logic all_same;
  assign beat = s_valid && s_ready;

  always_comb begin
    all_same = 1'b1;
    for (int c = 1; c < NCH; c++)
      if (chan_mode[c*MW +: MW] != chan_mode[MW-1:0]) all_same = 1'b0;
  end

  a_r1_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));
  a_r1_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> m_valid);
  a_r1_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r3_live: assert property (@(posedge clk) disable iff (!rst_n)
      beat && chan_mode[g*MW +: MW] == 4'd0 |=> m_data[g*DW +: DW] == $past(s_data[g*DW +: DW]));
    a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
      beat && chan_mode[g*MW +: MW] == 4'd1 |=> m_data[g*DW +: DW] == '0);
    a_r3_ones: assert property (@(posedge clk) disable iff (!rst_n)
      beat && chan_mode[g*MW +: MW] == 4'd2 |=> m_data[g*DW +: DW] == '1);
    a_r7_deskew: assert property (@(posedge clk) disable iff (!rst_n)
      beat && chan_mode[g*MW +: MW] == 4'd8 |=> m_data[g*DW +: DW] == DESKEW);
    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      beat && (chan_mode[g*MW +: MW] == 4'd5 || chan_mode[g*MW +: MW] == 4'd9 ||
               chan_mode[g*MW +: MW] >= 4'd12) |=> m_data[g*DW +: DW] == '0);
    if (g > 0) begin : g_align
      a_r12_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        beat && align_en && all_same && chan_mode[MW-1:0] != 4'd0
        |=> m_data[g*DW +: DW] == m_data[DW-1:0]);
    end
  end
endmodule

bind adc_test_pattern_gen adc_tpg_checker #(.NCH(NCH), .DW(DW), .MW(tpg_pkg::MODE_W)) i_tpg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .align_en  (align_en),
  .chan_mode (chan_mode),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .s_data    (s_data),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data)
);

// File: tb/test_adc_test_pattern_gen.sv
`timescale 1ns/1ps
module test_adc_test_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        align_en = 1'b0;
  logic [7:0]  chan_mode = '0;
  logic [15:0] custom_a = 16'h1234;
  logic [15:0] custom_b = 16'hFEDC;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [31:0] m_data;

  always #2.5 clk = ~clk;

  adc_test_pattern_gen i_adc_test_pattern_gen (
    .clk(clk), .rst_n(rst_n), .align_en(align_en), .chan_mode(chan_mode),
    .custom_a(custom_a), .custom_b(custom_b), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [3:0]  ma, mb;
  logic        al;
  logic [3:0]  mq [2];
  logic        alq;
  logic [15:0] st [2];
  logic [14:0] lf [2];
  logic [15:0] live_cnt = 16'h0100;
  logic [15:0] last_exp [2];

  // entry: mode_a, mode_b, align, beats
  localparam logic [13:0] VEC [15] = '{
    {4'd4,  4'd4,  1'b1, 5'd5},
    {4'd3,  4'd3,  1'b1, 5'd4},
    {4'd6,  4'd7,  1'b0, 5'd4},
    {4'd7,  4'd7,  1'b1, 5'd4},
    {4'd8,  4'd11, 1'b0, 5'd10},
    {4'd11, 4'd11, 1'b1, 5'd9},
    {4'd10, 4'd10, 1'b1, 5'd6},
    {4'd0,  4'd1,  1'b0, 5'd3},
    {4'd2,  4'd5,  1'b0, 5'd3},
    {4'd9,  4'd12, 1'b0, 5'd2},
    {4'd15, 4'd4,  1'b0, 5'd3},
    {4'd1,  4'd4,  1'b0, 5'd3},
    {4'd13, 4'd4,  1'b0, 5'd2},
    {4'd10, 4'd4,  1'b1, 5'd4},
    {4'd14, 4'd4,  1'b1, 5'd3}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [3:0] m);
    case (m)
      4'd0, 4'd1, 4'd2: return "R3";
      4'd3:  return "R4";
      4'd4:  return "R5";
      4'd6, 4'd7: return "R6";
      4'd8:  return "R7";
      4'd10: return "R8";
      4'd11: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] sine_ref(input logic [2:0] i);
    case (i)
      3'd0: return 16'd1;     3'd1: return 16'd9598;
      3'd2: return 16'd32768; 3'd3: return 16'd55938;
      3'd4: return 16'd65535; 3'd5: return 16'd55938;
      3'd6: return 16'd32768; default: return 16'd9598;
    endcase
  endfunction

  function automatic logic [30:0] prbs_ref(input logic [14:0] s0);
    logic [14:0] s = s0;
    logic [15:0] w = '0;
    logic b;
    for (int k = 0; k < 16; k++) begin
      b = s[14] ^ s[13];
      w = {w[14:0], b};
      s = {s[13:0], b};
    end
    return {w, s};
  endfunction

  task automatic model_reset();
    mq[0] = 4'd0; mq[1] = 4'd0; alq = 1'b0;
    st[0] = '0; st[1] = '0; lf[0] = '1; lf[1] = '1;
  endtask

  task automatic do_beat(input bit chk);
    logic [15:0] live [2];
    logic [15:0] exp [2];
    logic [3:0]  m;
    logic        anychg, rs;
    logic [30:0] pr;
    @(negedge clk);
    live_cnt = live_cnt + 16'h0137;
    live[0] = live_cnt; live[1] = ~live_cnt;
    s_valid = 1'b1; m_ready = 1'b1;
    chan_mode = {mb, ma}; align_en = al;
    s_data = {live[1], live[0]};
    anychg = (ma != mq[0]) || (mb != mq[1]);
    for (int c = 0; c < 2; c++) begin
      m  = (c == 0) ? ma : mb;
      rs = (m != mq[c]) || (al && (anychg || !alq));
      if (rs) begin st[c] = '0; lf[c] = '1; end
      pr = prbs_ref(lf[c]);
      case (m)
        4'd0:  exp[c] = live[c];
        4'd1:  exp[c] = 16'h0000;
        4'd2:  exp[c] = 16'hFFFF;
        4'd3:  exp[c] = st[c][0] ? 16'h5555 : 16'hAAAA;
        4'd4:  exp[c] = st[c];
        4'd6:  exp[c] = custom_a;
        4'd7:  exp[c] = st[c][0] ? custom_b : custom_a;
        4'd8:  exp[c] = 16'hAAAA;
        4'd10: exp[c] = pr[30:15];
        4'd11: exp[c] = sine_ref(st[c][2:0]);
        default: exp[c] = 16'h0000;
      endcase
      st[c] = st[c] + 16'd1;
      lf[c] = pr[14:0];
      mq[c] = m;
      last_exp[c] = exp[c];
    end
    alq = al;
    @(posedge clk); #1;
    if (chk) begin
      check(m_valid == 1'b1, "R1 valid after accept", {31'd0, m_valid}, 32'd1);
      check(m_data[15:0] == exp[0], tag(ma), {16'd0, m_data[15:0]}, {16'd0, exp[0]});
      check(m_data[31:16] == exp[1], tag(mb), {16'd0, m_data[31:16]}, {16'd0, exp[1]});
      if (al && ma == mb && ma != 4'd0)
        check(m_data[15:0] == m_data[31:16], "R12 lanes identical",
              {16'd0, m_data[31:16]}, {16'd0, m_data[15:0]});
    end
    s_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(m_valid == 1'b0, "R2 reset valid low", {31'd0, m_valid}, 32'd0);
    check(s_ready == 1'b1, "R2 reset ready high", {31'd0, s_ready}, 32'd1);

    // table walk: R3..R12 via reference model (R11 on rows where only one lane changes)
    for (int v = 0; v < 15; v++) begin
      ma = VEC[v][13:10]; mb = VEC[v][9:6]; al = VEC[v][5];
      for (int b = 0; b < int'(VEC[v][4:0]); b++) do_beat(1'b1);
    end

    // R6: custom word sampled at the beat
    ma = 4'd6; mb = 4'd7; al = 1'b0;
    do_beat(1'b1);
    @(negedge clk); custom_a = 16'h0F0F; custom_b = 16'h3C3C;
    do_beat(1'b1); do_beat(1'b1); do_beat(1'b1);

    // R13 / R1: stall keeps output and does not advance the ramp
    ma = 4'd4; mb = 4'd4; al = 1'b0;
    do_beat(1'b1); do_beat(1'b1);
    held = last_exp[0];
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); s_valid = 1'b1; m_ready = 1'b0;
      @(posedge clk); #1;
      check(s_ready == 1'b0, "R1 ready low on stall", {31'd0, s_ready}, 32'd0);
      check(m_valid && m_data[15:0] == held, "R1 hold on stall", {16'd0, m_data[15:0]}, {16'd0, held});
    end
    do_beat(1'b1);
    check(m_data[15:0] == held + 16'd1, "R13 ramp after stall", {16'd0, m_data[15:0]}, {16'd0, held + 16'd1});
    @(negedge clk); m_ready = 1'b1;
    @(posedge clk); #1;
    check(m_valid == 1'b0, "R1 drain drops valid", {31'd0, m_valid}, 32'd0);

    // R5: full ramp wrap
    ma = 4'd3; do_beat(1'b0);
    ma = 4'd4;
    for (int k = 0; k < 65535; k++) do_beat(1'b0);
    do_beat(1'b1);
    check(m_data[15:0] == 16'hFFFF, "R5 ramp top", {16'd0, m_data[15:0]}, 32'h0000FFFF);
    do_beat(1'b1);
    check(m_data[15:0] == 16'h0000, "R5 ramp wrap", {16'd0, m_data[15:0]}, 32'h0);

    // R2: mid-run reset restarts sequence
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    @(posedge clk); #1;
    check(m_valid == 1'b0, "R2 mid-run reset valid", {31'd0, m_valid}, 32'd0);
    do_beat(1'b1);
    check(m_data[15:0] == 16'h0000, "R2 ramp restarts after reset", {16'd0, m_data[15:0]}, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule